// File: doc/BRIEF.md
# Dish Control Tone-Burst Transmitter

This block drives the single control wire that commands satellite dish equipment by gating a fixed-frequency carrier. A programmable divider turns the system clock into the carrier. A two-bit mode selects what the wire carries: a constant low, a constant high, a continuous carrier, or a message sent from a small byte FIFO. A separate modulate bit chooses, in message mode, between bit cells that switch the carrier on and off and one unbroken carrier train that covers the whole message.

Each byte goes out MSB first and is followed by one odd-parity bit. Every bit is a cell of 33 carrier periods, timed in 11-period slots. A zero is two slots of carrier and then one idle slot. A one is one slot of carrier and then two idle slots. The message sequencer has three states. `ST_IDLE` waits; the transition *start* pops the FIFO and moves to `ST_WAIT`. `ST_WAIT` holds until the next carrier period boundary; the transition *align* then enters `ST_CELL`. `ST_CELL` times the bit cells. At the end of a cell it does one of three things: *next-bit* stays in the cell state, *next-byte* pops the FIFO and stays, and *finish* returns to `ST_IDLE` and pulses done. The transition *abort* (mode leaves message) returns to `ST_IDLE` from either busy state without a done pulse. When the message is over the wire is released to high impedance. A standby input freezes all timing and releases the wire.

Top module: `tone_burst_tx`

## Requirements
- R1: Out of standby, mode 2'b00 drives the wire low and mode 2'b01 drives it high (`line_oe`=1). In these modes the FIFO is neither read nor changed.
- R2: Mode 2'b11 drives a continuous carrier. The carrier period is 2*`half_period` clock cycles.
- R3: In mode 2'b10, out of standby, with the FIFO not empty, a message starts and `busy` rises. Bytes leave in FIFO order, MSB first. Each byte is followed by a parity bit chosen so that its 9 bits hold an odd number of ones (byte 8'h00 gives parity 1).
- R4: With `modulate`=1, each bit cell is 33 carrier periods long. A 0 is 22 periods of carrier and then 11 periods low. A 1 is 11 periods of carrier and then 22 periods low.
- R5: With `modulate`=0, the wire carries the carrier without a break for all 9*33 periods of every byte. A single 8'h00 byte therefore gives one train of 297 periods.
- R6: The message continues while the FIFO holds bytes. After the last parity bit, `done` pulses for exactly one cycle, `busy` is low in that same cycle, and in mode 2'b10 `line_oe` is 0 whenever `busy` is 0.
- R7: The FIFO holds 8 bytes and flags `fifo_full` and `fifo_empty`. A write while it is full is dropped.
- R8: While `standby`=1, `line_oe` is 0, the carrier and the bit timing are frozen, and no message starts. FIFO contents are kept, and timing resumes where it stopped.
- R9: A busy message lasts 297 carrier periods per byte, plus at most one period of alignment before the first cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Low-power hold: freezes timing, releases wire |
| mode | input | 2 | 00 low, 01 high, 10 message, 11 continuous carrier |
| modulate | input | 1 | Message mode: 1 bit cells, 0 unbroken train |
| half_period | input | 16 | Clock cycles per carrier half period |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 8 | Byte to queue |
| fifo_full | output | 1 | FIFO holds 8 bytes |
| fifo_empty | output | 1 | FIFO holds no byte |
| busy | output | 1 | Message in progress |
| done | output | 1 | One-cycle pulse after the last parity bit |
| line_out | output | 1 | Wire level when driven |
| line_oe | output | 1 | Wire drive enable (0 = high impedance) |

## Verification
A wrong slot counter shows up at the wire within one bit cell, as a carrier run of a length other than 11 or 22 periods. A wrong shift register or parity flag shows up as a wrong run length at the position of the bit it corrupts. A stuck sequencer state shows up as a missing or repeated done pulse, or a busy time that is wrong by whole cells, at the end of the message. FIFO pointer faults appear as bytes out of order, a lost ninth write, or a message of the wrong length.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_CELL = 2'd2
    } tbt_state_t;

    localparam logic [1:0] MODE_LOW  = 2'b00;
    localparam logic [1:0] MODE_HIGH = 2'b01;
    localparam logic [1:0] MODE_MSG  = 2'b10;
    localparam logic [1:0] MODE_TONE = 2'b11;
endpackage

// File: rtl/tbt_carrier.sv
module tbt_carrier #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze,
    input  logic [DIV_W-1:0] half_period,
    output logic             carrier,
    output logic             period_end
);
    logic [DIV_W-1:0] cnt;
    logic             half_last;

    assign half_last  = ({1'b0, cnt} + 1'b1) >= {1'b0, half_period};
    // carrier about to fall: one full period has elapsed
    assign period_end = !freeze && carrier && half_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            carrier <= 1'b0;
        end else if (!freeze) begin
            if (half_last) begin
                cnt     <= '0;
                carrier <= ~carrier;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tbt_fifo.sv
module tbt_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          full,
    output logic          empty
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW:0]   wptr, rptr;

    assign empty   = (wptr == rptr);
    assign full    = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
    assign rd_data = mem[rptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (wr_en && !full) mem[wptr[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (wr_en && !full) wptr <= wptr + 1'b1;
            if (rd_en && !empty) rptr <= rptr + 1'b1;
        end
    end
endmodule

// File: rtl/tbt_fsm.sv
module tbt_fsm
    import tbt_pkg::*;
#(
    parameter int SLOT_PERIODS = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       msg_mode,
    input  logic       freeze,
    input  logic       period_end,
    input  logic       fifo_empty,
    input  logic [7:0] fifo_data,
    output logic       fifo_rd,
    output logic       busy,
    output logic       done,
    output logic       in_cell,
    output logic       tone_on
);
    localparam int CELL_PERIODS = 3 * SLOT_PERIODS;
    localparam int SLOT_W       = $clog2(CELL_PERIODS);
    localparam logic [SLOT_W-1:0] CELL_LAST = SLOT_W'(CELL_PERIODS - 1);
    localparam logic [SLOT_W-1:0] ONE_ON    = SLOT_W'(SLOT_PERIODS);
    localparam logic [SLOT_W-1:0] ZERO_ON   = SLOT_W'(2 * SLOT_PERIODS);
    localparam logic [3:0]        PAR_IDX   = 4'd8;

    tbt_state_t        state, state_nx;
    logic [7:0]        shreg;
    logic              par;
    logic [3:0]        bit_idx;
    logic [SLOT_W-1:0] slot;
    logic              start, cell_end, last_bit, more, finish, cur_bit;

    assign start    = (state == ST_IDLE) && msg_mode && !freeze && !fifo_empty;
    assign cell_end = (state == ST_CELL) && period_end && (slot == CELL_LAST);
    assign last_bit = (bit_idx == PAR_IDX);
    assign more     = msg_mode && !fifo_empty;
    assign finish   = cell_end && last_bit && !more && msg_mode;
    assign cur_bit  = last_bit ? par : shreg[7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_WAIT;
            ST_WAIT: begin
                if (!msg_mode)       state_nx = ST_IDLE;
                else if (period_end) state_nx = ST_CELL;
            end
            ST_CELL: begin
                if (!msg_mode)   state_nx = ST_IDLE;
                else if (finish) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        fifo_rd = start || (cell_end && last_bit && more);
        busy    = (state != ST_IDLE);
        in_cell = (state == ST_CELL);
        tone_on = in_cell && (slot < (cur_bit ? ONE_ON : ZERO_ON));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            par     <= 1'b0;
            bit_idx <= '0;
            slot    <= '0;
            done    <= 1'b0;
        end else begin
            done <= finish;
            if (fifo_rd) begin
                shreg   <= fifo_data;
                par     <= ~^fifo_data;
                bit_idx <= '0;
                slot    <= '0;
            end else if ((state == ST_WAIT) && period_end) begin
                slot <= '0;
            end else if ((state == ST_CELL) && period_end) begin
                if (slot == CELL_LAST) begin
                    slot    <= '0;
                    bit_idx <= bit_idx + 1'b1;
                    shreg   <= {shreg[6:0], 1'b0};
                end else begin
                    slot <= slot + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tone_burst_tx.sv
module tone_burst_tx
    import tbt_pkg::*;
#(
    parameter int DIV_W        = 16,
    parameter int FIFO_DEPTH   = 8,
    parameter int SLOT_PERIODS = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic [1:0]       mode,
    input  logic             modulate,
    input  logic [DIV_W-1:0] half_period,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic             fifo_full,
    output logic             fifo_empty,
    output logic             busy,
    output logic             done,
    output logic             line_out,
    output logic             line_oe
);
    logic       carrier, period_end, fifo_rd, in_cell, tone_on;
    logic [7:0] fifo_data;

    tbt_carrier #(.DIV_W(DIV_W)) carrier_i (
        .clk(clk), .rst_n(rst_n), .freeze(standby), .half_period(half_period),
        .carrier(carrier), .period_end(period_end)
    );

    tbt_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) fifo_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(fifo_rd), .rd_data(fifo_data), .full(fifo_full), .empty(fifo_empty)
    );

    tbt_fsm #(.SLOT_PERIODS(SLOT_PERIODS)) fsm_i (
        .clk(clk), .rst_n(rst_n), .msg_mode(mode == MODE_MSG), .freeze(standby),
        .period_end(period_end), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_rd(fifo_rd), .busy(busy), .done(done), .in_cell(in_cell), .tone_on(tone_on)
    );

    always_comb begin
        line_oe  = 1'b0;
        line_out = 1'b0;
        if (!standby) begin
            unique case (mode)
                MODE_LOW:  begin line_oe = 1'b1; line_out = 1'b0;    end
                MODE_HIGH: begin line_oe = 1'b1; line_out = 1'b1;    end
                MODE_TONE: begin line_oe = 1'b1; line_out = carrier; end
                MODE_MSG:  begin
                    line_oe  = busy;
                    line_out = in_cell && carrier && (modulate ? tone_on : 1'b1);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tbt_checker.sv
module tbt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       standby,
    input logic [1:0] mode,
    input logic       fifo_full,
    input logic       fifo_empty,
    input logic       busy,
    input logic       done,
    input logic       line_out,
    input logic       line_oe
);
    a_r1_static_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!standby && mode == 2'b00) |-> (line_oe && !line_out));

    a_r1_static_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!standby && mode == 2'b01) |-> (line_oe && line_out));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && !busy) |-> !line_oe);

    a_r6_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && mode == 2'b10) |-> done);

    a_r7_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    a_r8_standby_float: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> !line_oe);

    a_r8_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && !busy) |=> !busy);
endmodule

bind tone_burst_tx tbt_checker chk_i (
    .clk(clk), .rst_n(rst_n), .standby(standby), .mode(mode),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .busy(busy), .done(done),
    .line_out(line_out), .line_oe(line_oe)
);

// File: tb/tone_burst_tx_tb_top.sv
module tone_burst_tx_tb_top;
    localparam int HALF   = 2;
    localparam int PERIOD = 2 * HALF;
    localparam int BYTE_CLK = 297 * PERIOD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        modulate = 1'b1;
    logic [15:0] half_period = 16'(HALF);
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        fifo_full, fifo_empty, busy, done, line_out, line_oe;

    tone_burst_tx dut_i (
        .clk(clk), .rst_n(rst_n), .standby(standby), .mode(mode), .modulate(modulate),
        .half_period(half_period), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .busy(busy), .done(done),
        .line_out(line_out), .line_oe(line_oe)
    );

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 1'b0;

    bit mon_on = 1'b0;
    int busy_cyc, done_cnt, rises, run, gap, n_runs;
    bit prev_lvl;
    int run_len [256];
    logic [7:0] exp_q [16];
    int n_exp;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
            summary();
        end
        if (mon_on) begin
            if (busy) busy_cyc++;
            if (done) done_cnt++;
            if (!standby) begin
                if (line_oe && line_out && !prev_lvl) begin
                    rises++; run++; gap = 0;
                end else begin
                    gap++;
                end
                if (run > 0 && gap > 2 * PERIOD) begin
                    if (n_runs < 256) run_len[n_runs] = run;
                    n_runs++;
                    run = 0;
                end
                prev_lvl = line_oe && line_out;
            end
        end
    end

    task automatic mon_start();
        @(posedge clk);
        busy_cyc = 0; done_cnt = 0; rises = 0; run = 0; gap = 0; n_runs = 0;
        prev_lvl = 1'b0;
        mon_on = 1'b1;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int cell_len(input logic [7:0] b, input int k);
        logic bitv;
        bitv = (k < 8) ? b[7-k] : ~^b;
        return bitv ? 11 : 22;
    endfunction

    // send the queued bytes in message mode and check the result
    task automatic run_message(input string tag);
        mon_start();
        @(negedge clk) mode = 2'b10;
        while (done_cnt == 0 && cyc < 189000) @(negedge clk);
        repeat (3 * PERIOD + 4) @(negedge clk);
        mon_on = 1'b0;
        chk(done_cnt == 1, {tag, " R6 done pulses"}, done_cnt, 1);
        chk(!line_oe, {tag, " R6 released"}, int'(line_oe), 0);
        chk(fifo_empty, {tag, " R6 drained"}, int'(fifo_empty), 1);
        chk(busy_cyc >= n_exp * BYTE_CLK && busy_cyc <= n_exp * BYTE_CLK + PERIOD + 2,
            {tag, " R9 busy length"}, busy_cyc, n_exp * BYTE_CLK);
        if (modulate) begin
            chk(n_runs == 9 * n_exp, {tag, " R4 run count"}, n_runs, 9 * n_exp);
            for (int i = 0; i < n_exp; i++) begin
                for (int k = 0; k < 9; k++) begin
                    if (9 * i + k < n_runs)
                        chk(run_len[9*i+k] == cell_len(exp_q[i], k),
                            {tag, " R3 R4 cell"}, run_len[9*i+k], cell_len(exp_q[i], k));
                end
            end
        end else begin
            chk(n_runs == 1, {tag, " R5 single train"}, n_runs, 1);
            chk(rises == 297 * n_exp, {tag, " R5 train periods"}, rises, 297 * n_exp);
        end
        @(negedge clk) mode = 2'b00;
        n_exp = 0;
    endtask

    task automatic queue(input logic [7:0] b);
        push(b);
        if (n_exp < 16) exp_q[n_exp] = b;
        n_exp++;
    endtask

    initial begin
        void'($urandom(32'd2741));
        n_exp = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fifo_empty && !fifo_full, "R7 reset flags", int'(fifo_empty), 1);
        chk(!busy && !done, "R6 reset idle", int'(busy), 0);
        chk(line_oe && !line_out, "R1 reset low", int'(line_out), 0);

        // R1: static levels, FIFO untouched
        queue(8'hA5);
        @(negedge clk) mode = 2'b01;
        repeat (200) @(negedge clk);
        chk(line_oe && line_out, "R1 static high", int'(line_out), 1);
        chk(!fifo_empty, "R1 FIFO kept in static mode", int'(fifo_empty), 0);
        @(negedge clk) mode = 2'b00;
        repeat (50) @(negedge clk);
        chk(line_oe && !line_out, "R1 static low", int'(line_out), 0);

        // R2: continuous carrier
        @(negedge clk) mode = 2'b11;
        mon_start();
        repeat (400) @(negedge clk);
        mon_on = 1'b0;
        chk(rises >= 99 && rises <= 101, "R2 carrier rate", rises, 100);
        chk(!fifo_empty, "R1 FIFO kept in tone mode", int'(fifo_empty), 0);
        @(negedge clk) mode = 2'b00;

        // R3 R4: queued byte from above, modulated
        modulate = 1'b1;
        run_message("directed A5");

        // R5: unmodulated burst
        modulate = 1'b0;
        queue(8'h00);
        run_message("unmod 00");

        // modulated FF and 00
        modulate = 1'b1;
        queue(8'hFF);
        queue(8'h00);
        run_message("mod FF 00");

        // random messages
        for (int it = 0; it < 4; it++) begin
            int nb;
            nb = 1 + int'($urandom % 3);
            for (int j = 0; j < nb; j++) queue(8'($urandom));
            run_message("random");
        end

        // R7: fill, overflow write dropped
        for (int j = 0; j < 8; j++) queue(8'($urandom));
        chk(fifo_full, "R7 full at 8", int'(fifo_full), 1);
        push(8'h3C);
        chk(fifo_full, "R7 still full", int'(fifo_full), 1);
        run_message("full8");

        // R8: standby blocks start, keeps FIFO
        queue(8'h96);
        @(negedge clk) standby = 1'b1;
        mode = 2'b10;
        repeat (100) @(negedge clk);
        chk(!busy && !fifo_empty, "R8 no start in standby", int'(busy), 0);
        chk(!line_oe, "R8 wire released", int'(line_oe), 0);
        mode = 2'b00;
        @(negedge clk) standby = 1'b0;

        // R8: standby in the middle of a message freezes timing
        mon_start();
        @(negedge clk) mode = 2'b10;
        repeat (300) @(negedge clk);
        standby = 1'b1;
        repeat (500) @(negedge clk);
        chk(busy && !line_oe, "R8 frozen busy", int'(busy), 1);
        standby = 1'b0;
        while (done_cnt == 0 && cyc < 189000) @(negedge clk);
        repeat (3 * PERIOD + 4) @(negedge clk);
        mon_on = 1'b0;
        chk(n_runs == 9, "R8 resume run count", n_runs, 9);
        for (int k = 0; k < 9; k++)
            if (k < n_runs)
                chk(run_len[k] == cell_len(8'h96, k), "R8 resume cell", run_len[k], cell_len(8'h96, k));
        chk(busy_cyc >= BYTE_CLK + 500, "R8 timing held", busy_cyc, BYTE_CLK + 500);
        @(negedge clk) mode = 2'b00;
        n_exp = 0;

        summary();
    end
endmodule